// File: doc/BRIEF.md
# Always-On Watchdog Timer Register

This block is a hardware watchdog that cannot be switched off. A CPU sees it as a single 8-bit read/write register. The register carries a 6-bit down-counter stored with its bit order mirrored, a software-reset control bit and an activation flag. Each pulse on the prescaled tick input moves the counter one step towards zero. When the counter runs out, the block requests a chip reset for one clock cycle. Software keeps the chip alive by rewriting the register often enough, and it can force a reset at once by writing the control bit low.

Every reset event, whether from expiry or from software, puts the whole register back to its power-up image. That image is 0xFE: the counter is all ones, the control bit is one and the activation flag is zero. The activation flag belongs to hardware. It reports that the counter has started stepping, and software writes to it have no effect. No register value stops the counter.

The register port is plain control. A write strobe is taken in any cycle, with no back-pressure and no handshake, and read data is valid combinationally in every cycle. The reset request is a plain level pin. The bench holds the counter width at its default of 6.

Top module: `hw_watchdog`

## Requirements
- R1: After the reset input is released, rd_data reads 0xFE and rst_req is low.
- R2: Read layout: rd_data[7] is the counter LSB and rd_data[2] is its MSB, with each bit in between in mirrored order. rd_data[1] always reads 1 and rd_data[0] reads the activation flag.
- R3: A write with wr_data[1]=1 loads the counter from wr_data[7:2], un-mirrored so that wr_data[7] becomes the counter LSB. The new value shows on rd_data in the next cycle.
- R4: A tick with no write in the same cycle and a counter of 2 or more lowers the counter by exactly one, and rst_req stays low.
- R5: A tick with no write in the same cycle and a counter of 0 or 1 raises rst_req in the next cycle for exactly one cycle, and the register reads 0xFE from that same cycle on.
- R6: A write with wr_data[1]=0 raises rst_req in the next cycle for exactly one cycle and returns the register to 0xFE. The other bits of that write are disregarded.
- R7: The activation flag reads 0 after any reset event and becomes 1 on the first tick that does not expire the counter. Writes to bit 0 never change it.
- R8: When a write and a tick fall in the same cycle, the write is carried out and that tick is lost.
- R9: No written value disables the watchdog. A loaded counter of zero expires on the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data, current counter and flags |
| tick | input | 1 | Prescaled count pulse, one cycle wide |
| rst_req | output | 1 | One-cycle chip reset request |

## Verification
Every one of the 64 counter values is written through the mirrored field and read back, and each is then followed by a tick. This separates correct un-mirroring from a straight or shifted mapping, and it separates decrement from expiry at the 0/1 boundary. A full countdown from the all-ones value checks that rst_req fires after exactly 63 ticks and for exactly one cycle. Writes with the control bit low are combined with varied counter fields, and writes are made to coincide with ticks. These show that a software reset ignores the rest of the data, that a write takes priority over a tick, and that writes to bit 0 never reach the activation flag.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int SR_BIT    = 1;
  localparam int ACT_BIT   = 0;
  localparam int FIELD_LSB = 2;
endpackage

// File: rtl/wdt_bitrev.sv
module wdt_bitrev #(
  parameter int W = 6
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_mirror
    assign dout[i] = din[W-1-i];
  end
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restore,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '1;
    else if (restore)           cnt <= '1;
    else if (load)              cnt <= load_val;
    else if (dec && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assert_tick_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && !restore && cnt > W'(1)) |=> (cnt == $past(cnt) - 1'b1));

  assert_restore_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> (cnt == '1));
endmodule

// File: rtl/wdt_req_gen.sv
module wdt_req_gen #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_clear,
  input  logic         tick_eff,
  input  logic [W-1:0] cnt,
  output logic         restore,
  output logic         act,
  output logic         rst_req
);
  logic expire;

  assign expire  = tick_eff && (cnt <= W'(1));
  assign restore = sw_clear || expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req <= 1'b0;
      act     <= 1'b0;
    end else begin
      rst_req <= restore;
      if (restore)       act <= 1'b0;
      else if (tick_eff) act <= 1'b1;
    end
  end

  assert_expire_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_eff && cnt <= W'(1)) |=> rst_req);

  assert_swclear_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clear |=> (rst_req && !act));

  assert_act_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_eff && cnt > W'(1)) |=> act);
endmodule

// File: rtl/hw_watchdog.sv
module hw_watchdog #(
  parameter  int CNT_W = 6,
  localparam int REG_W = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             tick,
  output logic             rst_req
);
  import wdt_pkg::*;

  logic [CNT_W-1:0] field_in;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] field_out;
  logic             wr_load;
  logic             sw_clear;
  logic             tick_eff;
  logic             restore;
  logic             act;

  assign field_in = wr_data[REG_W-1:FIELD_LSB];
  assign sw_clear = wr_en && !wr_data[SR_BIT];
  assign wr_load  = wr_en && wr_data[SR_BIT];
  assign tick_eff = tick && !wr_en;

  wdt_bitrev #(.W(CNT_W)) u_unmirror (
    .din  (field_in),
    .dout (load_val)
  );

  wdt_down_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .restore  (restore),
    .load     (wr_load),
    .load_val (load_val),
    .dec      (tick_eff),
    .cnt      (cnt)
  );

  wdt_req_gen #(.W(CNT_W)) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_clear (sw_clear),
    .tick_eff (tick_eff),
    .cnt      (cnt),
    .restore  (restore),
    .act      (act),
    .rst_req  (rst_req)
  );

  wdt_bitrev #(.W(CNT_W)) u_mirror (
    .din  (cnt),
    .dout (field_out)
  );

  assign rd_data = {field_out, 1'b1, act};

  assert_load_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[SR_BIT]) |=> (rd_data[REG_W-1:FIELD_LSB] == $past(wr_data[REG_W-1:FIELD_LSB])));

  assert_act_ignores_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[SR_BIT] && (wr_data[ACT_BIT] != rd_data[ACT_BIT]))
      |=> (rd_data[ACT_BIT] == $past(rd_data[ACT_BIT])));

  assert_req_restores_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (rd_data == {{CNT_W{1'b1}}, 2'b10}));

  assert_sr_reads_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[SR_BIT]);
endmodule

// File: tb/sim_hw_watchdog.sv
`timescale 1ns/1ps
module sim_hw_watchdog;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       tick = 1'b0;
  logic       rst_req;

  int n_chk = 0;
  int n_bad = 0;
  int exp_cnt = 63;
  bit exp_act = 1'b0;
  bit exp_req = 1'b0;

  always #2.5 clk = ~clk;

  hw_watchdog u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .tick    (tick),
    .rst_req (rst_req)
  );

  function automatic [5:0] mir(input [5:0] v);
    for (int i = 0; i < 6; i++) mir[i] = v[5-i];
  endfunction

  function automatic [7:0] exp_rd();
    return {mir(exp_cnt[5:0]), 1'b1, exp_act};
  endfunction

  task automatic check(input string tag, input [7:0] got_rd, input bit got_req);
    n_chk++;
    if (got_rd !== exp_rd() || got_req !== exp_req) begin
      n_bad++;
      $display("FAIL %s: rd_data=%02h rst_req=%0b expected rd_data=%02h rst_req=%0b",
               tag, got_rd, got_req, exp_rd(), exp_req);
    end
  endtask

  task automatic step(input bit w, input [7:0] d, input bit t, input string tag);
    wr_en = w; wr_data = d; tick = t;
    @(posedge clk); #1;
    wr_en = 1'b0; tick = 1'b0;
    exp_req = 1'b0;
    if (w) begin
      if (!d[1]) begin exp_req = 1'b1; exp_cnt = 63; exp_act = 1'b0; end
      else exp_cnt = int'(mir(d[7:2]));
    end else if (t) begin
      if (exp_cnt <= 1) begin exp_req = 1'b1; exp_cnt = 63; exp_act = 1'b0; end
      else begin exp_cnt = exp_cnt - 1; exp_act = 1'b1; end
    end
    check(tag, rd_data, rst_req);
  endtask

  initial begin
    #400000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #7 rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 reset image", rd_data, rst_req);
    step(1'b0, 8'h00, 1'b0, "R1 idle after reset");
    step(1'b1, 8'h83, 1'b0, "R2 R7 natural one at bit7, bit0 write ignored");
    step(1'b1, 8'h06, 1'b0, "R2 MSB at bit2");

    for (int v = 0; v < 64; v++) begin
      step(1'b1, {mir(v[5:0]), 1'b1, v[0]}, 1'b0, "R3 load sweep");
      step(1'b0, 8'h00, 1'b1, (v >= 2) ? "R4 tick step" : "R5 R9 tick expiry");
      step(1'b0, 8'h00, 1'b0, "R5 one-cycle request");
    end

    step(1'b1, 8'hFE, 1'b0, "R3 reload full");
    for (int k = 0; k < 62; k++) step(1'b0, 8'h00, 1'b1, "R4 countdown");
    step(1'b0, 8'h00, 1'b0, "R4 no request at count 1");
    step(1'b0, 8'h00, 1'b1, "R5 expiry after 63 ticks");
    step(1'b0, 8'h00, 1'b0, "R5 request drops");
    step(1'b0, 8'h00, 1'b1, "R7 act set by first tick");
    step(1'b1, 8'h52, 1'b0, "R7 write bit0 low leaves act");

    for (int d = 0; d < 256; d += 37) begin
      step(1'b0, 8'h00, 1'b1, "R7 tick before clear");
      step(1'b1, 8'(d) & 8'hFD, 1'b0, "R6 software clear");
      step(1'b0, 8'h00, 1'b0, "R6 request single cycle");
    end

    step(1'b1, 8'h22, 1'b1, "R8 write wins over tick");
    step(1'b1, 8'h03, 1'b1, "R8 zero load with tick");
    step(1'b0, 8'h00, 1'b0, "R9 zero held");
    step(1'b1, 8'h01, 1'b1, "R8 R6 clear with tick");
    step(1'b1, 8'h03, 1'b0, "R9 load zero again");
    step(1'b0, 8'h00, 1'b1, "R9 zero count expires");
    step(1'b0, 8'h00, 1'b0, "R9 request drops");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule